// File: doc/BRIEF.md
# Two-Wire Register Slave with Pointer Auto-Increment

This block is a slave on a two-wire serial bus (I2C-compatible) that runs entirely on the system clock. It samples the clock and data lines through synchronizers and decodes start, repeated start and stop conditions from the synchronized samples. It answers one fixed 7-bit device address and gives byte access to an external register file through an internal byte pointer. The first byte of a write sets the pointer. Every later byte is stored at the pointer, and the pointer then advances. A read returns the byte at the pointer and advances the pointer for as long as the master keeps acknowledging.

Two commands restore the register file defaults. One is a pointer byte of 0xBF. The other is the general-call address followed by 0x06. Either one pulses a load strobe towards the register file. After the pulse the slave ignores the bus for a programmable number of clock cycles. The data line is driven open-drain: the slave only ever pulls it low.

Top module: `i2c_regslave`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0), `reg_addr` is 0x00 and `reg_we` is low.
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. After a start, the first byte arrives MSB first. The slave acknowledges it by holding the data line low for the ninth clock only when its upper seven bits equal `DEV_ADDR` (0x48, so the byte is 0x90 for a write and 0x91 for a read) or when the byte is 0x00. Any other address gets no acknowledge.
- R3: In a write, the first byte after the address is loaded into the pointer and acknowledged. Each later byte is acknowledged and presented on `reg_wdata` with a one-cycle `reg_we` at the pointer address, and the pointer increments in that same cycle.
- R4: In a read, the byte at the pointer is shifted out MSB first. A master acknowledge increments the pointer and starts the next byte. A master no-acknowledge sends the slave idle with the pointer unchanged.
- R5: A stop condition sets the pointer to 0x00, so a read that starts without a pointer write returns register 0x00.
- R6: A repeated start is handled exactly like a start. The pointer kept from the earlier part of the transfer stays in use.
- R7: A data byte written while the pointer is at or above `NUM_REGS` is acknowledged but never produces `reg_we`. The pointer still advances.
- R8: A pointer byte of 0xBF is acknowledged. At the falling clock edge that ends its acknowledge, `defaults_load` pulses for one cycle and the pointer returns to 0x00.
- R9: After the general-call address (0x00), a command byte of 0x06 is acknowledged and pulses `defaults_load` as in R8. Any other command byte is not acknowledged and produces no load.
- R10: For `BUSY_CYCLES` clock cycles after `defaults_load`, start conditions are ignored, no byte is acknowledged and `sda_oe` stays low.
- R11: `sda_oe` changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | Pull the data line low when 1 (open-drain drive) |
| reg_addr | output | 8 | Current pointer, used as the register file address |
| reg_wdata | output | 8 | Received data byte |
| reg_we | output | 1 | One-cycle write strobe into the register file |
| reg_rdata | input | 8 | Register file contents at `reg_addr` |
| defaults_load | output | 1 | One-cycle request to restore register defaults |

## Verification
The write strobe and the pointer advance happen in the same clock cycle. A wrong ordering would store each byte one address off or skip an address. The bench drives multibyte writes from random start pointers, including runs that cross the `NUM_REGS` boundary, and then reads the range back. Each returned byte is compared with a model in which byte k of the burst lands at pointer plus k. The default-load pulse and the pointer clear also share a cycle. This is judged by reading from address 0x00 after the busy window and by confirming that an address sent inside the window gets no acknowledge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK
    } phase_e;

    typedef enum logic [1:0] {
        B_ADDR,
        B_PTR,
        B_DATA,
        B_GCMD
    } bkind_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    localparam logic [7:0] PTR_RESET_CMD = 8'hBF;
    localparam logic [7:0] GC_RESET_CMD  = 8'h06;
    localparam logic [7:0] GC_ADDR_BYTE  = 8'h00;

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync import i2cs_pkg::*; #(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [1:0] ff [STAGES];
    logic       scl_q, sda_q;
    logic       scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) ff[i] <= 2'b11;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            ff[0] <= {scl_i, sda_i};
            for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s = ff[STAGES-1][1];
    assign sda_s = ff[STAGES-1][0];

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cs_busy.sv
module i2cs_busy #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic busy
);
    localparam int W = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (trigger)      cnt <= W'(CYCLES);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm import i2cs_pkg::*; #(
    parameter logic [6:0] DEV_ADDR = 7'h48,
    parameter int         NUM_REGS = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic       busy,
    input  logic [7:0] reg_rdata,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    output logic       defaults_load
);
    localparam logic [8:0] LIMIT = 9'(NUM_REGS);

    phase_e     phase;
    bkind_e     kind;
    logic [3:0] cnt;
    logic [7:0] shreg, txsh, ptr;
    logic       rd_mode, gcall, rst_pend, macked;
    logic       byte_done, ack_byte;

    assign byte_done = ev.fall && (phase == S_RX) && (cnt == 4'd8);

    always_comb begin
        unique case (kind)
            B_ADDR:  ack_byte = !busy && (addr_hit(shreg, DEV_ADDR) || shreg == GC_ADDR_BYTE);
            B_GCMD:  ack_byte = (shreg == GC_RESET_CMD);
            default: ack_byte = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= S_IDLE;
            kind     <= B_ADDR;
            cnt      <= '0;
            shreg    <= '0;
            txsh     <= '0;
            ptr      <= '0;
            rd_mode  <= 1'b0;
            gcall    <= 1'b0;
            rst_pend <= 1'b0;
            macked   <= 1'b0;
        end else if (ev.stop) begin
            phase    <= S_IDLE;
            ptr      <= '0;
            rst_pend <= 1'b0;
            macked   <= 1'b0;
        end else if (ev.start) begin
            phase    <= busy ? S_IDLE : S_RX;
            kind     <= B_ADDR;
            cnt      <= '0;
            rst_pend <= 1'b0;
            macked   <= 1'b0;
        end else begin
            case (phase)
                S_RX: begin
                    if (ev.rise && cnt != 4'd8) begin
                        shreg <= {shreg[6:0], ev.sda};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_done) begin
                        if (ack_byte) begin
                            phase <= S_ACK;
                            case (kind)
                                B_ADDR: begin
                                    rd_mode <= shreg[0];
                                    gcall   <= (shreg == GC_ADDR_BYTE);
                                end
                                B_PTR: begin
                                    ptr      <= shreg;
                                    rst_pend <= (shreg == PTR_RESET_CMD);
                                end
                                B_DATA:  ptr      <= ptr + 8'd1;
                                default: rst_pend <= 1'b1;
                            endcase
                        end else begin
                            phase <= S_IDLE;
                        end
                    end
                end
                S_ACK: begin
                    if (ev.fall) begin
                        cnt <= '0;
                        if (rst_pend) begin
                            phase    <= S_IDLE;
                            ptr      <= '0;
                            rst_pend <= 1'b0;
                        end else if (kind == B_ADDR) begin
                            if (gcall) begin
                                phase <= S_RX;
                                kind  <= B_GCMD;
                            end else if (rd_mode) begin
                                phase <= S_TX;
                                txsh  <= reg_rdata;
                            end else begin
                                phase <= S_RX;
                                kind  <= B_PTR;
                            end
                        end else begin
                            phase <= S_RX;
                            kind  <= B_DATA;
                        end
                    end
                end
                S_TX: begin
                    if (ev.fall) begin
                        if (cnt == 4'd7) begin
                            phase <= S_MACK;
                            cnt   <= '0;
                        end else begin
                            txsh <= {txsh[6:0], 1'b0};
                            cnt  <= cnt + 4'd1;
                        end
                    end
                end
                S_MACK: begin
                    if (ev.rise) begin
                        if (!ev.sda) begin
                            ptr    <= ptr + 8'd1;
                            macked <= 1'b1;
                        end else begin
                            phase <= S_IDLE;
                        end
                    end else if (ev.fall && macked) begin
                        phase  <= S_TX;
                        txsh   <= reg_rdata;
                        macked <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe        = (phase == S_ACK) || (phase == S_TX && !txsh[7]);
    assign reg_addr      = ptr;
    assign reg_wdata     = shreg;
    assign reg_we        = byte_done && (kind == B_DATA) && ({1'b0, ptr} < LIMIT);
    assign defaults_load = ev.fall && (phase == S_ACK) && rst_pend;
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave import i2cs_pkg::*; #(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         NUM_REGS    = 24,
    parameter int         BUSY_CYCLES = 100000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata,
    output logic       defaults_load
);
    bus_ev_t ev_w;
    logic    busy_w;

    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev_w)
    );

    i2cs_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk     (clk),
        .rst     (rst),
        .trigger (defaults_load),
        .busy    (busy_w)
    );

    i2cs_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .ev            (ev_w),
        .busy          (busy_w),
        .reg_rdata     (reg_rdata),
        .sda_oe        (sda_oe),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_we        (reg_we),
        .defaults_load (defaults_load)
    );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk import i2cs_pkg::*; (
    input logic       clk,
    input logic       rst,
    input logic       sda_oe,
    input logic       reg_we,
    input logic [7:0] reg_addr,
    input logic       defaults_load,
    input logic       busy,
    input bus_ev_t    ev
);
    // R3
    ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> reg_addr == $past(reg_addr) + 8'd1);

    // R3
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R5
    stop_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> reg_addr == 8'h00);

    // R8
    load_clear_chk: assert property (@(posedge clk) disable iff (rst)
        defaults_load |=> (reg_addr == 8'h00 && busy));

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !ev.scl);
endmodule

bind i2c_regslave i2cs_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .sda_oe        (sda_oe),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .defaults_load (defaults_load),
    .busy          (busy_w),
    .ev            (ev_w)
);

// File: tb/tb_i2c_regslave.sv
module tb_i2c_regslave;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 10;
    localparam int NREG       = 24;
    localparam int BUSY       = 1000;
    localparam int NRAND      = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, reg_we, defaults_load;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic [7:0] mem [32];
    logic [7:0] exp_mem [32];
    logic [7:0] wbuf [8];
    logic oe_q;
    int checks = 0, errors = 0;
    int load_cnt = 0, bad_we = 0, oe_hi_chg = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regslave #(.NUM_REGS(NREG), .BUSY_CYCLES(BUSY)) dut (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .sda_oe        (sda_oe),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_we        (reg_we),
        .reg_rdata     (reg_rdata),
        .defaults_load (defaults_load)
    );

    function automatic logic [7:0] dflt(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] exp_rd(input int a);
        int m = a & 255;
        if (m < NREG) return exp_mem[m];
        return 8'(m) ^ 8'h5A;
    endfunction

    assign reg_rdata = (reg_addr < 8'(NREG)) ? mem[reg_addr[4:0]] : (reg_addr ^ 8'h5A);

    always_ff @(posedge clk) begin
        oe_q <= sda_oe;
        if (rst || defaults_load) begin
            for (int i = 0; i < 32; i++) mem[i] <= dflt(i);
        end else if (reg_we && reg_addr < 8'(NREG)) begin
            mem[reg_addr[4:0]] <= reg_wdata;
        end
        if (!rst) begin
            if (defaults_load) load_cnt <= load_cnt + 1;
            if (reg_we && reg_addr >= 8'(NREG)) bad_we <= bad_we + 1;
            if (sda_oe != oe_q && scl_m) oe_hi_chg <= oe_hi_chg + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bitx(input logic v, output logic s);
        sda_m = v;
        cyc(QTR);
        scl_m = 1'b1;
        cyc(QTR);
        s = sda_line;
        scl_m = 1'b0;
        cyc(QTR);
    endtask

    task automatic start_c;
        sda_m = 1'b1; cyc(QTR);
        scl_m = 1'b1; cyc(QTR);
        sda_m = 1'b0; cyc(QTR);
        scl_m = 1'b0; cyc(QTR);
    endtask

    task automatic stop_c;
        sda_m = 1'b0; cyc(QTR);
        scl_m = 1'b1; cyc(QTR);
        sda_m = 1'b1; cyc(QTR);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bitx(b[i], s);
        bitx(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bitx(1'b1, s);
            d[i] = s;
        end
        bitx(~mack, s);
    endtask

    task automatic wr_txn(input int p, input int n);
        logic a;
        start_c;
        send_byte(8'h90, a); chk(a, "R2 write address ack", int'(a), 1);
        send_byte(8'(p), a); chk(a, "R3 pointer byte ack", int'(a), 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a);
            if (p + k < NREG) begin
                chk(a, "R3 data byte ack", int'(a), 1);
                exp_mem[p + k] = wbuf[k];
            end else begin
                chk(a, "R7 invalid address still acked", int'(a), 1);
            end
        end
        stop_c;
    endtask

    task automatic rd_txn(input int p, input bit setp, input int n);
        logic a;
        logic [7:0] d;
        int base;
        base = setp ? p : 0;
        start_c;
        if (setp) begin
            send_byte(8'h90, a); chk(a, "R2 write address ack", int'(a), 1);
            send_byte(8'(p), a); chk(a, "R3 pointer byte ack", int'(a), 1);
            start_c;
            send_byte(8'h91, a); chk(a, "R6 read address after repeated start", int'(a), 1);
        end else begin
            send_byte(8'h91, a); chk(a, "R5 read address ack", int'(a), 1);
        end
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            if (setp)
                chk(d == exp_rd(base + k), "R4 read data", int'(d), int'(exp_rd(base + k)));
            else
                chk(d == exp_rd(base + k), "R5 read from cleared pointer", int'(d), int'(exp_rd(base + k)));
        end
        stop_c;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary;
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        int lc;
        void'($urandom(32'd7331));
        for (int i = 0; i < 32; i++) exp_mem[i] = dflt(i);
        cyc(5);
        rst = 1'b0;
        cyc(2);

        // R1 reset state
        chk(sda_oe == 1'b0, "R1 sda released", int'(sda_oe), 0);
        chk(reg_addr == 8'h00, "R1 pointer zero", int'(reg_addr), 0);
        chk(reg_we == 1'b0, "R1 no write strobe", int'(reg_we), 0);

        // R2 wrong device address is not acknowledged
        start_c;
        send_byte(8'h92, a); chk(!a, "R2 foreign address nack", int'(a), 0);
        stop_c;

        // R3 directed burst then R4/R6 readback, R5 poll
        wbuf[0] = 8'hA1; wbuf[1] = 8'h5C; wbuf[2] = 8'h3E;
        wr_txn(3, 3);
        rd_txn(3, 1'b1, 3);
        wbuf[0] = 8'hC4;
        wr_txn(0, 1);
        rd_txn(0, 1'b0, 2);

        // R7 burst crossing the end of the register space
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wr_txn(22, 3);
        chk(bad_we == 0, "R7 no strobe beyond NUM_REGS", bad_we, 0);
        rd_txn(22, 1'b1, 3);

        // R4 master NACK leaves pointer unchanged
        start_c;
        send_byte(8'h90, a); chk(a, "R2 write address ack", int'(a), 1);
        send_byte(8'h05, a); chk(a, "R3 pointer byte ack", int'(a), 1);
        start_c;
        send_byte(8'h91, a); chk(a, "R6 repeated start read ack", int'(a), 1);
        recv_byte(1'b0, d); chk(d == exp_mem[5], "R4 single read", int'(d), int'(exp_mem[5]));
        start_c;
        send_byte(8'h91, a); chk(a, "R6 second repeated start ack", int'(a), 1);
        recv_byte(1'b0, d); chk(d == exp_mem[5], "R4 NACK keeps pointer", int'(d), int'(exp_mem[5]));
        stop_c;

        // constrained random bursts
        for (int t = 0; t < NRAND; t++) begin
            int p, n;
            p = $urandom_range(0, NREG - 1);
            n = $urandom_range(1, 5);
            if ((t % 2) == 0) begin
                for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom_range(0, 255));
                wr_txn(p, n);
            end else begin
                rd_txn(p, 1'b1, n);
            end
        end
        chk(bad_we == 0, "R7 no strobe beyond NUM_REGS after random", bad_we, 0);

        // R9 general call with a foreign command
        lc = load_cnt;
        start_c;
        send_byte(8'h00, a); chk(a, "R9 general call ack", int'(a), 1);
        send_byte(8'h07, a); chk(!a, "R9 other command nack", int'(a), 0);
        stop_c;
        cyc(4);
        chk(load_cnt == lc, "R9 no load on other command", load_cnt, lc);
        start_c;
        send_byte(8'h90, a); chk(a, "R9 not busy after rejected command", int'(a), 1);
        stop_c;

        // R8 soft reset through pointer 0xBF, R10 busy window
        lc = load_cnt;
        start_c;
        send_byte(8'h90, a); chk(a, "R2 write address ack", int'(a), 1);
        send_byte(8'hBF, a); chk(a, "R8 reset pointer acked", int'(a), 1);
        chk(load_cnt == lc + 1, "R8 defaults load pulse", load_cnt, lc + 1);
        stop_c;
        start_c;
        send_byte(8'h90, a); chk(!a, "R10 nack while busy", int'(a), 0);
        stop_c;
        cyc(BUSY + 200);
        for (int i = 0; i < 32; i++) exp_mem[i] = dflt(i);
        rd_txn(0, 1'b0, 3);

        // R9 general call reset
        wbuf[0] = 8'h77;
        wr_txn(2, 1);
        lc = load_cnt;
        start_c;
        send_byte(8'h00, a); chk(a, "R9 general call ack", int'(a), 1);
        send_byte(8'h06, a); chk(a, "R9 reset command ack", int'(a), 1);
        stop_c;
        chk(load_cnt == lc + 1, "R9 defaults load pulse", load_cnt, lc + 1);
        start_c;
        send_byte(8'h91, a); chk(!a, "R10 read nack while busy", int'(a), 0);
        stop_c;
        cyc(BUSY + 200);
        for (int i = 0; i < 32; i++) exp_mem[i] = dflt(i);
        rd_txn(2, 1'b1, 1);

        // R11 drive only changes while the clock line is low
        chk(oe_hi_chg == 0, "R11 sda_oe stable while scl high", oe_hi_chg, 0);

        done = 1'b1;
        summary;
        $finish;
    end
endmodule